// File: doc/BRIEF.md
# Interrupt Interval Delay Monitor

This block watches a periodic interrupt source and measures, in microseconds, the gap between one interrupt event and the next. A free-running 1 µs tick enable supplies the time base. Each interrupt event pulse closes the interval that is open and starts a new one. The block reports the interval that closed last and the largest interval seen since the last clear. It also counts how often an interval exceeded a lower and an upper threshold.

Intended use is as a jitter and worst-case delay gauge. The source normally fires about 5760 times per second, so the gap sits near 173 µs. Gaps above 400 µs and above 1000 µs show that service was stalled. The block measures the spacing between events, not the latency from trigger to service. The lower-threshold count is nested: it also includes every interval that the upper-threshold count records. A clear strobe restarts the statistics.

Top module: `ivm_monitor`

## Requirements
- R1: An interval equals the number of tick pulses seen from the cycle of the previous accepted event up to, but not including, the cycle of the closing event. A tick in the event cycle itself counts toward the interval that event opens.
- R2: The first event after reset or clear only starts timing. It changes neither the current interval, the maximum, nor either counter.
- R3: `cur_interval` takes the closed interval's value in the cycle after the event pulse and holds it until the next closing event.
- R4: `max_interval` replaces its value only when a closed interval is strictly greater, so it always holds the largest interval since clear and never decreases between clears.
- R5: `over_lo_cnt` increments once for each closed interval strictly greater than LO_LIMIT (default 400).
- R6: `over_hi_cnt` increments once for each closed interval strictly greater than HI_LIMIT (default 1000). Every such interval is also counted by `over_lo_cnt`, so `over_lo_cnt` is never below `over_hi_cnt`.
- R7: Both event counters saturate at all-ones (2^EVT_W-1) and do not wrap.
- R8: The running interval timer saturates at all-ones (2^CNT_W-1). An interval longer than that is reported as all-ones.
- R9: `clr` zeroes the current interval, the maximum and both counters on the next edge, and re-arms the first-event condition. An event in the same cycle as `clr` is ignored.
- R10: Cycles without `tick_us` add no time, so intervals are measured in ticks, not clock cycles.
- R11: Synchronous active-high `rst` brings every output to zero and disarms the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle 1 µs time-base enable |
| irq_evt | input | 1 | One-cycle interrupt event pulse |
| clr | input | 1 | Statistics clear strobe |
| cur_interval | output | CNT_W | Most recent closed interval in ticks |
| max_interval | output | CNT_W | Largest interval since clear |
| over_lo_cnt | output | EVT_W | Intervals above LO_LIMIT, saturating |
| over_hi_cnt | output | EVT_W | Intervals above HI_LIMIT, saturating |

## Verification
Several properties hold on every cycle, so the assertions check them continuously. The lower count never falls below the upper count. The maximum never falls below the current interval, and it never shrinks unless a clear occurs. A clear zeroes the statistics on the next edge. A saturated timer stays at all-ones. Other behaviour depends on a sequence of stimulus, so only the bench scenarios can show it. This covers the exact tick arithmetic of each interval and the silent first event after a clear. It also covers threshold edges at the limit and one above it, counter saturation, and a clear that lands together with an event.

// File: rtl/ivm_pkg.sv
package ivm_pkg;

    typedef enum logic {
        ARM_IDLE   = 1'b0,
        ARM_TIMING = 1'b1
    } arm_e;

    typedef struct packed {
        logic        vld;
        logic [31:0] val;
    } sample_t;

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] top);
        return (v >= top) ? top : v + 32'd1;
    endfunction

endpackage

// File: rtl/ivm_timer.sv
module ivm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             evt,
    output logic [CNT_W-1:0] elapsed,
    output logic             smp_vld
);
    import ivm_pkg::*;

    localparam logic [31:0] TOP = 32'((64'd1 << CNT_W) - 64'd1);

    arm_e        arm_q;
    logic [31:0] nxt;

    assign smp_vld = evt && !clr && (arm_q == ARM_TIMING);

    always_comb begin
        nxt = sat_inc(32'(elapsed), TOP);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            arm_q   <= ARM_IDLE;
            elapsed <= '0;
        end else if (evt) begin
            arm_q   <= ARM_TIMING;
            elapsed <= tick ? CNT_W'(1) : '0;
        end else if (tick) begin
            elapsed <= nxt[CNT_W-1:0];
        end
    end

    assert_timer_sat_R8: assert property (@(posedge clk) disable iff (rst)
        (elapsed == TOP[CNT_W-1:0] && !evt && !clr) |=> (elapsed == TOP[CNT_W-1:0]));

    assert_timer_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !evt && !clr) |=> $stable(elapsed));

endmodule

// File: rtl/ivm_peak.sv
module ivm_peak #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_vld,
    input  logic [CNT_W-1:0] smp_val,
    output logic [CNT_W-1:0] cur,
    output logic [CNT_W-1:0] peak
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur  <= '0;
            peak <= '0;
        end else if (smp_vld) begin
            cur <= smp_val;
            if (smp_val > peak) peak <= smp_val;
        end
    end

    assert_peak_ge_cur_R4: assert property (@(posedge clk) disable iff (rst)
        peak >= cur);

    assert_peak_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> peak >= $past(peak));

    assert_cur_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !clr) |=> $stable(cur));

endmodule

// File: rtl/ivm_bin.sv
module ivm_bin #(
    parameter int CNT_W = 16,
    parameter int EVT_W = 16,
    parameter int LIMIT = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_vld,
    input  logic [CNT_W-1:0] smp_val,
    output logic [EVT_W-1:0] count
);
    import ivm_pkg::*;

    localparam logic [31:0] LIM32 = 32'(LIMIT);
    localparam logic [31:0] TOP   = 32'((64'd1 << EVT_W) - 64'd1);

    logic        over;
    logic [31:0] nxt;

    always_comb begin
        over = smp_vld && (32'(smp_val) > LIM32);
        nxt  = sat_inc(32'(count), TOP);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (over)  count <= nxt[EVT_W-1:0];
    end

    assert_bin_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && count == TOP[EVT_W-1:0]) |=> (count == TOP[EVT_W-1:0]));

endmodule

// File: rtl/ivm_monitor.sv
module ivm_monitor #(
    parameter int CNT_W    = 16,
    parameter int EVT_W    = 16,
    parameter int LO_LIMIT = 400,
    parameter int HI_LIMIT = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_us,
    input  logic             irq_evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cur_interval,
    output logic [CNT_W-1:0] max_interval,
    output logic [EVT_W-1:0] over_lo_cnt,
    output logic [EVT_W-1:0] over_hi_cnt
);
    localparam int NBIN = 2;

    logic [CNT_W-1:0] elapsed;
    logic             smp_vld;
    logic [EVT_W-1:0] bin_cnt [NBIN];

    ivm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick_us), .evt(irq_evt),
        .elapsed(elapsed), .smp_vld(smp_vld)
    );

    ivm_peak #(.CNT_W(CNT_W)) u_peak (
        .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_val(elapsed),
        .cur(cur_interval), .peak(max_interval)
    );

    for (genvar g = 0; g < NBIN; g++) begin : g_bin
        localparam int LIM = (g == 0) ? LO_LIMIT : HI_LIMIT;
        ivm_bin #(.CNT_W(CNT_W), .EVT_W(EVT_W), .LIMIT(LIM)) u_bin (
            .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_val(elapsed),
            .count(bin_cnt[g])
        );
    end

    assign over_lo_cnt = bin_cnt[0];
    assign over_hi_cnt = bin_cnt[1];

    assert_lo_covers_hi_R6: assert property (@(posedge clk) disable iff (rst)
        over_lo_cnt >= over_hi_cnt);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cur_interval == '0 && max_interval == '0 &&
                 over_lo_cnt == '0 && over_hi_cnt == '0));

    assert_first_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_evt && !smp_vld) |=> ($stable(over_lo_cnt) && $stable(over_hi_cnt) &&
                                   $stable(max_interval) || $past(clr)));

endmodule

// File: tb/ivm_monitor_test.sv
module ivm_monitor_test;
    localparam int CW = 6;
    localparam int EW = 3;
    localparam int LO = 4;
    localparam int HI = 10;
    localparam int CMAX = (1 << CW) - 1;
    localparam int EMAX = (1 << EW) - 1;

    logic clk = 1'b0;
    logic rst, tick_us, irq_evt, clr;
    logic [CW-1:0] cur_interval, max_interval;
    logic [EW-1:0] over_lo_cnt, over_hi_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int m_elap, m_cur, m_max, m_lo, m_hi;
    bit m_arm;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ivm_monitor #(.CNT_W(CW), .EVT_W(EW), .LO_LIMIT(LO), .HI_LIMIT(HI)) uut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .irq_evt(irq_evt), .clr(clr),
        .cur_interval(cur_interval), .max_interval(max_interval),
        .over_lo_cnt(over_lo_cnt), .over_hi_cnt(over_hi_cnt)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_elap = 0; m_cur = 0; m_max = 0; m_lo = 0; m_hi = 0; m_arm = 0;
    endtask

    // one clock: drive at negedge, update the requirement model, compare at the next negedge
    task automatic cyc(input bit e, input bit t, input bit c, input string tag);
        irq_evt = e; tick_us = t; clr = c;
        @(posedge clk);
        if (c) model_clear();
        else if (e) begin
            if (m_arm) begin
                m_cur = m_elap;
                if (m_elap > m_max) m_max = m_elap;
                if (m_elap > LO && m_lo < EMAX) m_lo++;
                if (m_elap > HI && m_hi < EMAX) m_hi++;
            end
            m_arm = 1;
            m_elap = t ? 1 : 0;
        end else if (t && m_elap < CMAX) m_elap++;
        @(negedge clk);
        irq_evt = 0; tick_us = 0; clr = 0;
        cmp({tag, " R3 cur"}, int'(cur_interval), m_cur);
        cmp({tag, " R4 max"}, int'(max_interval), m_max);
        cmp({tag, " R5 lo"},  int'(over_lo_cnt), m_lo);
        cmp({tag, " R6 hi"},  int'(over_hi_cnt), m_hi);
    endtask

    // event, then gap-1 ticking idle cycles, then the closing event comes from the next call
    task automatic gap(input int g, input string tag);
        cyc(1, 1, 0, tag);
        for (int i = 1; i < g; i++) cyc(0, 1, 0, tag);
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        irq_evt = 0; tick_us = 0; clr = 0; rst = 1;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11 reset state
        cmp("R11 cur", int'(cur_interval), 0);
        cmp("R11 max", int'(max_interval), 0);
        cmp("R11 lo", int'(over_lo_cnt), 0);
        cmp("R11 hi", int'(over_hi_cnt), 0);

        // R2 first event is silent even after a long run of ticks
        for (int i = 0; i < 20; i++) cyc(0, 1, 0, "R2 pre");
        cyc(1, 1, 0, "R2 first");
        cmp("R2 first no max", int'(max_interval), 0);

        // R1 R5 R6 R8 sweep of gap lengths with continuous ticks, interval == gap
        for (int g = 1; g <= CMAX + 4; g++) begin
            gap(g, "R1 sweep");
        end
        cyc(1, 1, 0, "R1 close");
        cmp("R8 saturated max", int'(max_interval), CMAX);
        cmp("R7 lo saturated", int'(over_lo_cnt), EMAX);
        cmp("R7 hi saturated", int'(over_hi_cnt), EMAX);

        // R9 clear zeroes all and re-arms; event with clear ignored
        cyc(0, 1, 1, "R9 clear");
        cmp("R9 max zero", int'(max_interval), 0);
        cyc(1, 1, 1, "R9 clr+evt");
        for (int i = 0; i < 15; i++) cyc(0, 1, 0, "R9 idle");
        cyc(1, 1, 0, "R9 rearm first");
        cmp("R9 first after clear", int'(cur_interval), 0);

        // R5 R6 boundaries: gaps at limit and one above
        gap(LO, "R5 at limit");
        gap(LO + 1, "R5 above");
        gap(HI, "R6 at limit");
        gap(HI + 1, "R6 above");
        cyc(1, 1, 0, "R6 close");
        cmp("R5 lo boundary", int'(over_lo_cnt), 3);
        cmp("R6 hi boundary", int'(over_hi_cnt), 1);

        // R4 smaller interval keeps max, equal does not disturb
        gap(3, "R4 small");
        cyc(1, 1, 0, "R4 close");
        cmp("R4 max held", int'(max_interval), HI + 1);
        cmp("R3 cur small", int'(cur_interval), 3);

        // R10 sparse tick patterns: interval counts ticks only
        for (int p = 1; p <= 5; p++) begin
            cyc(1, 0, 0, "R10 open");
            for (int i = 0; i < 4 * p + 3; i++) cyc(0, (i % p) == 0, 0, "R10 sparse");
        end
        cyc(1, 0, 0, "R10 close");
        for (int i = 0; i < 6; i++) cyc(1, 0, 0, "R10 zero ticks");
        cmp("R10 zero gap", int'(cur_interval), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule